// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple host request port and an asynchronous DRAM array built from four byte lanes that share one eleven-bit multiplexed address bus. A host word address is split into an 11-bit row (upper half) and an 11-bit column (lower half). On a fresh access the controller drives the row, pulls both RAS groups low, switches the bus to the column and pulls low the CAS strobe of each enabled byte lane. It then leaves the row open, so that later requests to the same row cost only a CAS cycle.

Writes are always early writes. W goes low, and the controller drives the shared data bus, one clock before any CAS strobe falls, so the array never drives the bus during a write. Read data is captured from the bus on the clock edge that ends the CAS pulse. It is returned with a one-cycle valid pulse, and the bytes of lanes that were not enabled read as zero. Every analog minimum is given in nanoseconds and turned into whole clock cycles, rounded up, from a clock-period parameter.

A request to another row closes the open row and starts a full precharge. So does a page-open timer that nears the limit on how long RAS may stay low. A separate refresh sequencer can ask for the array with a request line. The controller closes the row and grants the array only once the precharge time has run out.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: After reset, both RAS groups, all four CAS strobes and W are high, rd_valid and sq_gnt are low, and req_ready is high.
- R2: Host address bits [21:11] appear on the DRAM address bus when RAS falls, and bits [10:0] appear when CAS falls. Words in different rows are kept apart.
- R3: Byte enable bit i drives CAS strobe i, which gates DQ[8i+7:8i]. Strobes of disabled lanes stay high, and only enabled bytes are written. RAS group 0 (lanes 0–1) and RAS group 1 (lanes 2–3) move together.
- R4: On a write, W is low and write data is on the bus one clock before CAS falls. On a read, W stays high for the whole time CAS is low.
- R5: Each read returns one rd_valid pulse, exactly one cycle long, in request order. rd_data holds the addressed word, with the bytes of disabled lanes forced to zero.
- R6: A request to the row already open is served by a CAS cycle alone, with no new RAS fall.
- R7: A request to a different row closes the row. RAS stays high for at least ceil(T_RP/CLK) cycles, and two RAS falls are at least ceil(T_RC/CLK) cycles apart.
- R8: RAS-to-CAS delay ≥ ceil(T_RCD/CLK). CAS low ≥ ceil(T_CAS/CLK). CAS high ≥ ceil(T_CP/CLK). Successive CAS falls ≥ ceil(T_PC/CLK) apart. RAS low ≥ ceil(T_RAS/CLK) cycles, and no CAS strobe is low while RAS is high.
- R9: RAS never stays low longer than ceil(T_RASP/CLK) cycles. An idle open row is closed by the page timer.
- R10: While sq_req is high, req_ready is low. sq_gnt rises only with RAS, CAS and W high and the precharge time met.
- R11: Each request is taken on one clock edge with req_valid and req_ready both high, and it produces exactly one CAS cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*A_W | Word address: row in upper half, column in lower half |
| req_be | input | LANES | Byte-lane enables |
| req_wdata | input | 8*LANES | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8*LANES | Read data, disabled lanes zero |
| sq_req | input | 1 | Refresh sequencer asks for the array |
| sq_gnt | output | 1 | Array idle and precharged, handed to the sequencer |
| dram_a | output | A_W | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, lower and upper lane pairs |
| dram_cas_n | output | LANES | Column strobe per byte lane |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | 8*LANES | Shared data bus |

## Verification
The bench builds the controller with a 10 ns clock and every timing minimum at its default, so precharge, row-cycle, RAS-to-CAS and page-cycle limits are 4, 11, 2 and 4 cycles. The page-open limit is cut to 900 ns (90 cycles). A row left idle is then closed by the timer within about a hundred cycles, instead of ten thousand. A behavioural lane-by-lane array model on the DRAM pins measures every strobe interval in clock cycles. A scoreboard compares each returned read with a byte-merged shadow of all earlier writes.

// File: rtl/pagemode_dram_ctrl.sv
`timescale 1ns/1ps
module pagemode_dram_ctrl #(
  parameter int CLK_NS     = 10,
  parameter int A_W        = 11,
  parameter int LANES      = 4,
  parameter int T_RC_NS    = 110,
  parameter int T_RP_NS    = 40,
  parameter int T_RAS_NS   = 60,
  parameter int T_RASP_NS  = 100000,
  parameter int T_RCD_NS   = 20,
  parameter int T_RAH_NS   = 10,
  parameter int T_CAS_NS   = 15,
  parameter int T_CP_NS    = 10,
  parameter int T_PC_NS    = 40,
  parameter int T_CAC_NS   = 15,
  parameter int T_RAC_NS   = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [2*A_W-1:0]     req_addr,
  input  logic [LANES-1:0]     req_be,
  input  logic [8*LANES-1:0]   req_wdata,
  output logic                 rd_valid,
  output logic [8*LANES-1:0]   rd_data,
  input  logic                 sq_req,
  output logic                 sq_gnt,
  output logic [A_W-1:0]       dram_a,
  output logic [1:0]           dram_ras_n,
  output logic [LANES-1:0]     dram_cas_n,
  output logic                 dram_we_n,
  inout  wire  [8*LANES-1:0]   dram_dq
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RC_C   = to_cyc(T_RC_NS);
  localparam int RP_C   = to_cyc(T_RP_NS);
  localparam int RAS_C  = to_cyc(T_RAS_NS);
  localparam int PAGE_C = to_cyc(T_RASP_NS);
  localparam int RCD_C  = to_cyc(T_RCD_NS);
  localparam int RAH_C  = to_cyc(T_RAH_NS);
  localparam int CASL_C = to_cyc(T_CAS_NS);
  localparam int CP_C   = to_cyc(T_CP_NS);
  localparam int PC_C   = to_cyc(T_PC_NS);
  localparam int CAC_C  = to_cyc(T_CAC_NS);
  localparam int RAC_C  = to_cyc(T_RAC_NS);
  localparam int GUARD  = PC_C + CP_C + CASL_C + CAC_C + 2;
  localparam int SF_MAX = imax(PAGE_C, RC_C);
  localparam int SF_W   = $clog2(SF_MAX + 1);
  localparam int SM_MAX = imax(imax(PC_C, CASL_C), imax(imax(CAC_C, CP_C), RP_C));
  localparam int SM_W   = $clog2(SM_MAX + 1);
  localparam int DW     = 8 * LANES;

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_COL, S_CAS, S_OPEN} st_t;
  st_t st;

  logic            ras_q;
  logic [LANES-1:0] cas_q;
  logic            we_n_q, dq_oe, we_q;
  logic [DW-1:0]   dq_o, lane_mask;
  logic [A_W-1:0]  open_row, col_q;
  logic [LANES-1:0] be_q;
  logic [SF_W-1:0] since_fall;
  logic [SM_W-1:0] since_rise, since_cas, cas_hi;
  int sf1, sr1, sc1, ch1;

  assign sf1 = int'(since_fall) + 1;
  assign sr1 = int'(since_rise) + 1;
  assign sc1 = int'(since_cas) + 1;
  assign ch1 = int'(cas_hi) + 1;

  wire [A_W-1:0] req_row = req_addr[2*A_W-1:A_W];
  wire [A_W-1:0] req_col = req_addr[A_W-1:0];
  wire hit      = (req_row == open_row);
  wire expire   = sf1 >= PAGE_C - GUARD;
  wire prech_ok = (sr1 >= RP_C) && (sf1 >= RC_C);
  wire close_rq = sq_req || expire || (req_valid && !hit);

  assign req_ready = !sq_req && (((st == S_IDLE) && prech_ok) ||
                                 ((st == S_OPEN) && hit && !expire));
  wire accept = req_valid && req_ready;
  assign sq_gnt = sq_req && (st == S_IDLE) && prech_ok;

  assign dram_ras_n = {2{ras_q}};
  assign dram_cas_n = cas_q;
  assign dram_we_n  = we_n_q;
  assign dram_dq    = dq_oe ? dq_o : {DW{1'bz}};

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{be_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ras_q      <= 1'b1;
      cas_q      <= '1;
      we_n_q     <= 1'b1;
      dq_oe      <= 1'b0;
      dq_o       <= '0;
      we_q       <= 1'b0;
      be_q       <= '0;
      open_row   <= '0;
      col_q      <= '0;
      dram_a     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      since_fall <= SF_W'(SF_MAX);
      since_rise <= SM_W'(SM_MAX);
      since_cas  <= SM_W'(SM_MAX);
      cas_hi     <= SM_W'(SM_MAX);
    end else begin
      rd_valid <= 1'b0;
      if (since_fall != SF_W'(SF_MAX)) since_fall <= since_fall + SF_W'(1);
      if (since_rise != SM_W'(SM_MAX)) since_rise <= since_rise + SM_W'(1);
      if (since_cas  != SM_W'(SM_MAX)) since_cas  <= since_cas + SM_W'(1);
      if (cas_hi     != SM_W'(SM_MAX)) cas_hi     <= cas_hi + SM_W'(1);
      case (st)
        S_IDLE: if (accept) begin
          ras_q      <= 1'b0;
          since_fall <= '0;
          dram_a     <= req_row;
          open_row   <= req_row;
          col_q      <= req_col;
          be_q       <= req_be;
          we_q       <= req_we;
          dq_o       <= req_wdata;
          st         <= S_RCD;
        end
        S_RCD: if (sf1 >= RAH_C) begin
          dram_a <= col_q;
          we_n_q <= !we_q;
          dq_oe  <= we_q;
          st     <= S_COL;
        end
        S_COL: if (sf1 >= RCD_C && ch1 >= CP_C && sc1 >= PC_C) begin
          cas_q     <= ~be_q;
          since_cas <= '0;
          st        <= S_CAS;
        end
        S_CAS: if (sc1 >= CASL_C && (we_q || (sc1 >= CAC_C && sf1 >= RAC_C))) begin
          cas_q  <= '1;
          cas_hi <= '0;
          we_n_q <= 1'b1;
          dq_oe  <= 1'b0;
          if (!we_q) begin
            rd_valid <= 1'b1;
            rd_data  <= dram_dq & lane_mask;
          end
          st <= S_OPEN;
        end
        S_OPEN: if (accept) begin
          dram_a <= req_col;
          col_q  <= req_col;
          be_q   <= req_be;
          we_q   <= req_we;
          dq_o   <= req_wdata;
          we_n_q <= !req_we;
          dq_oe  <= req_we;
          st     <= S_COL;
        end else if (close_rq && sf1 >= RAS_C) begin
          ras_q      <= 1'b1;
          since_rise <= '0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cas_in_ras_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&dram_cas_n) |-> (dram_ras_n == 2'b00));
  p_rcd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&dram_cas_n) |-> sf1 > RCD_C);
  p_cas_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dram_cas_n) & (~be_q)) == '0);
  p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&dram_cas_n) |-> $stable(dram_we_n) && (dram_we_n || dq_oe));
  p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&dram_cas_n) && !(&$past(dram_cas_n))) |-> $stable(dram_we_n));
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_page_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n[0] |-> sf1 <= PAGE_C);
  p_gnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_gnt |-> (&dram_ras_n) && (&dram_cas_n) && dram_we_n);
  p_no_ready_sq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req |-> !req_ready);

endmodule

// File: tb/pagemode_dram_ctrl_tb.sv
`timescale 1ns/1ps
module pagemode_dram_ctrl_tb;
  localparam int RP_C = 4, RAS_C = 6, RC_C = 11, RCD_C = 2, CASL_C = 2;
  localparam int CP_C = 1, PC_C = 4, PAGE_C = 90;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, sq_req = 0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, sq_gnt, dram_we_n;
  logic [31:0] rd_data;
  logic [10:0] dram_a;
  logic [1:0] dram_ras_n;
  logic [3:0] dram_cas_n;
  wire  [31:0] dram_dq;

  logic [3:0] drv = '0;
  logic [31:0] rdq = '0;
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign dram_dq[8*g +: 8] = drv[g] ? rdq[8*g +: 8] : 8'bz;
  end

  always #5 clk = ~clk;

  pagemode_dram_ctrl #(.T_RASP_NS(900)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sq_req(sq_req), .sq_gnt(sq_gnt),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq(dram_dq));

  int errors = 0, checks = 0, n_req = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // array model and strobe timing monitor
  logic [7:0] mem [int];
  logic [10:0] cur_row = '0, last_row = '0, last_col = '0;
  logic p_ras = 1, p_we = 1;
  logic [3:0] p_cas = 4'hF;
  int ras_lo_cnt = 0, ras_hi_cnt = 100, since_fall = 100, cas_lo_cnt = 0;
  int cas_hi_cnt = 100, since_cas = 100, ras_falls = 0, cas_acc = 0;

  always @(negedge clk) if (rst_n) begin
    logic ras, cas_on, p_cas_on;
    ras = dram_ras_n[0];
    cas_on = !(&dram_cas_n);
    p_cas_on = !(&p_cas);
    if (p_ras && !ras) begin
      chk(dram_ras_n[0] == dram_ras_n[1], "R3", "RAS groups together", 32'(dram_ras_n), 32'h0);
      chk(ras_hi_cnt >= RP_C, "R7", "RAS precharge cycles", ras_hi_cnt, RP_C);
      chk(since_fall >= RC_C, "R7", "RAS cycle", since_fall, RC_C);
      cur_row = dram_a; last_row = dram_a; ras_falls++;
    end
    if (!p_ras && ras) begin
      chk(dram_ras_n == 2'b11, "R3", "RAS groups together", 32'(dram_ras_n), 32'h3);
      chk(ras_lo_cnt >= RAS_C, "R8", "RAS low cycles", ras_lo_cnt, RAS_C);
      chk(ras_lo_cnt <= PAGE_C, "R9", "RAS low limit", ras_lo_cnt, PAGE_C);
    end
    if (cas_on && !p_cas_on) begin
      chk(!ras, "R8", "CAS inside RAS", 32'(ras), 32'h0);
      chk(ras_lo_cnt >= RCD_C || p_ras, "R8", "RAS to CAS", ras_lo_cnt, RCD_C);
      chk(cas_hi_cnt >= CP_C, "R8", "CAS high", cas_hi_cnt, CP_C);
      chk(since_cas >= PC_C, "R8", "page cycle", since_cas, PC_C);
      if (!dram_we_n) chk(!p_we, "R4", "W low before CAS", 32'(p_we), 32'h0);
      last_col = dram_a; cas_acc++;
    end
    if (!cas_on && p_cas_on)
      chk(cas_lo_cnt >= CASL_C, "R8", "CAS low", cas_lo_cnt, CASL_C);
    if (cas_on && p_cas_on && dram_we_n != p_we)
      chk(0, "R4", "W changed while CAS low", 32'(dram_we_n), 32'(p_we));
    for (int i = 0; i < 4; i++) begin
      int key;
      key = (i << 22) | (int'(cur_row) << 11) | int'(dram_a);
      if (p_cas[i] && !dram_cas_n[i]) begin
        if (!dram_we_n) begin
          chk(!$isunknown(dram_dq[8*i +: 8]), "R4", "write data driven", 32'(dram_dq[8*i +: 8]), 32'h0);
          mem[key] = dram_dq[8*i +: 8];
        end else begin
          rdq[8*i +: 8] = mem.exists(key) ? mem[key] : 8'h00;
          drv[i] = 1'b1;
        end
      end
      if (!p_cas[i] && dram_cas_n[i]) drv[i] = 1'b0;
    end
    since_fall = (p_ras && !ras) ? 1 : since_fall + 1;
    since_cas  = (cas_on && !p_cas_on) ? 1 : since_cas + 1;
    if (ras == p_ras) begin if (ras) ras_hi_cnt++; else ras_lo_cnt++; end
    else begin if (ras) ras_hi_cnt = 1; else ras_lo_cnt = 1; end
    if (cas_on == p_cas_on) begin if (cas_on) cas_lo_cnt++; else cas_hi_cnt++; end
    else begin if (cas_on) cas_lo_cnt = 1; else cas_hi_cnt = 1; end
    p_ras = ras; p_cas = dram_cas_n; p_we = dram_we_n;
  end

  // scoreboard
  logic [31:0] shadow [int];
  logic [31:0] expq [$];
  logic p_rdv = 0;

  always @(negedge clk) if (rst_n) begin
    if (rd_valid && p_rdv) chk(0, "R5", "rd_valid longer than one cycle", 32'h1, 32'h0);
    if (rd_valid) begin
      if (expq.size() == 0) chk(0, "R5", "unexpected read data", rd_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R5", "read data", rd_data, e);
      end
    end
    p_rdv = rd_valid;
  end

  task automatic access(bit we, logic [10:0] row, logic [10:0] col, logic [3:0] be, logic [31:0] d);
    logic [21:0] a;
    logic [31:0] cur;
    a = {row, col};
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0;
    for (int i = 0; i < 4; i++) begin
      if (we && be[i]) cur[8*i +: 8] = d[8*i +: 8];
      if (!we && !be[i]) cur[8*i +: 8] = 8'h00;
    end
    if (we) shadow[int'(a)] = cur; else expq.push_back(cur);
    n_req++;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (expq.size() == 0 && req_ready) break;
    end
    chk(expq.size() == 0, "R5", "reads returned", expq.size(), 0);
  endtask

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(dram_ras_n == 2'b11, "R1", "RAS after reset", 32'(dram_ras_n), 32'h3);
    chk(dram_cas_n == 4'hF, "R1", "CAS after reset", 32'(dram_cas_n), 32'hF);
    chk(dram_we_n == 1'b1, "R1", "W after reset", 32'(dram_we_n), 32'h1);
    chk(!rd_valid && !sq_gnt, "R1", "rd_valid/sq_gnt after reset", {rd_valid, sq_gnt}, 32'h0);
    chk(req_ready, "R1", "ready after reset", 32'(req_ready), 32'h1);

    // R6: page hits
    f0 = ras_falls;
    access(1, 11'd5, 11'd3, 4'hF, 32'h11223344);
    access(0, 11'd5, 11'd3, 4'hF, 32'h0);
    access(1, 11'd5, 11'd7, 4'b0101, 32'hAABBCCDD);
    access(0, 11'd5, 11'd7, 4'hF, 32'h0);
    drain();
    chk(ras_falls - f0 == 1, "R6", "one RAS fall for same row", ras_falls - f0, 1);
    chk(last_row == 11'd5, "R2", "row on bus at RAS fall", 32'(last_row), 32'd5);

    // R7/R2: row miss
    access(0, 11'd9, 11'd3, 4'hF, 32'h0);
    drain();
    chk(ras_falls - f0 == 2, "R7", "miss reopens row", ras_falls - f0, 2);
    chk(last_row == 11'd9, "R2", "row on bus at RAS fall", 32'(last_row), 32'd9);
    chk(last_col == 11'd3, "R2", "column on bus at CAS fall", 32'(last_col), 32'd3);
    access(0, 11'd5, 11'd3, 4'hF, 32'h0);
    drain();
    chk(ras_falls - f0 == 3, "R7", "back to first row", ras_falls - f0, 3);

    // R3/R5: byte lanes
    access(1, 11'd9, 11'd1, 4'hF, 32'h01020304);
    access(1, 11'd9, 11'd1, 4'b0100, 32'hFFEEDDCC);
    access(0, 11'd9, 11'd1, 4'b0011, 32'h0);
    access(0, 11'd9, 11'd1, 4'hF, 32'h0);
    access(0, 11'd2047, 11'd2047, 4'b1000, 32'h0);
    access(1, 11'd2047, 11'd2047, 4'b1000, 32'h5A000000);
    access(0, 11'd2047, 11'd2047, 4'hF, 32'h0);
    drain();

    // R9: page timer closes an idle row
    repeat (120) @(negedge clk);
    #1;
    chk(dram_ras_n == 2'b11, "R9", "idle row closed by timer", 32'(dram_ras_n), 32'h3);

    // R10: sequencer handshake
    access(1, 11'd2, 11'd4, 4'hF, 32'hCAFEF00D);
    @(negedge clk);
    sq_req = 1;
    #1;
    chk(!req_ready, "R10", "ready low while sequencer asks", 32'(req_ready), 32'h0);
    for (int k = 0; k < 60; k++) begin
      if (sq_gnt) break;
      @(negedge clk); #1;
    end
    chk(sq_gnt, "R10", "grant given", 32'(sq_gnt), 32'h1);
    chk(dram_ras_n == 2'b11 && dram_cas_n == 4'hF, "R10", "array idle at grant",
        {dram_ras_n, dram_cas_n}, 32'h3F);
    chk(ras_hi_cnt >= RP_C, "R10", "precharge before grant", ras_hi_cnt, RP_C);
    f0 = cas_acc;
    req_valid = 1; req_we = 0; req_addr = {11'd2, 11'd4}; req_be = 4'hF;
    repeat (8) @(negedge clk);
    #1;
    chk(!req_ready && cas_acc == f0, "R10", "no access while granted", cas_acc - f0, 0);
    req_valid = 0;
    sq_req = 0;
    @(negedge clk); #1;
    chk(!sq_gnt, "R10", "grant drops", 32'(sq_gnt), 32'h0);
    access(0, 11'd2, 11'd4, 4'hF, 32'h0);
    drain();

    chk(cas_acc == n_req, "R11", "one CAS cycle per request", cas_acc, n_req);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule